// File: doc/BRIEF.md
# UART Register Bank with Prioritized Interrupt

This block is the processor-facing control and status section of a simple serial port. A memory-mapped bus reads and writes 32-bit registers. Each access is indexed by the byte address with its two low bits dropped. A byte-stream handshake connects the block to an external deserializer and serializer. The block keeps the interrupt-enable, interrupt-identification, line-status and modem-status registers, and it drives one level-sensitive interrupt line.

Receive storage is a single byte. While that byte waits for software, the block lowers its ready signal toward the deserializer. A byte that arrives anyway is counted as an overrun and discarded. Transmit storage is also a single byte. A write to the data register loads it, and it is offered on the transmit stream until the consumer takes it. The pending interrupt sources are ranked in a fixed four-level order. The identification register always reports the highest-ranked enabled source.

The bus read path is combinational: `bus_rdata` is valid in the same cycle as `bus_sel`, and is zero when `bus_sel` is low. All state changes take effect at the rising clock edge that ends the access.

Top module: `urb_top`

## Requirements
- R1: After a synchronous reset: line status reads 0x60 (bit5 transmit-holding-empty, bit6 transmitter-empty); interrupt enable and modem status read 0; identification reads 0x01; `irq` and `tx_valid` are low; `rx_ready` is high.
- R2: The register index is `bus_addr[4:2]`. The map is: 0 data, 1 interrupt enable (bits 3:0 read/write), 2 identification (read-only), 5 line status (read-only), 6 modem status (bits 7:0 read/write). Reads of indices 3, 4 and 7 return 0.
- R3: A `rx_valid` pulse while data-ready (line status bit0) is clear stores `rx_data` and sets data-ready. `rx_ready` is high exactly while data-ready is clear.
- R4: A read of the data register returns the held byte and clears data-ready at the end of the access.
- R5: A `rx_valid` pulse while data-ready is set sets overrun (bit1) and discards the new byte. If that pulse coincides with a data-register read, the new byte is instead accepted and overrun stays clear.
- R6: An accepted byte sets parity (bit2), framing (bit3) and break (bit4) from `rx_perr`, `rx_ferr`, `rx_brk`. A line-status read returns the flags and then clears bits 4:1. A flag raised in the same cycle as the read survives it.
- R7: A data write while bit5 is set places `bus_wdata[7:0]` on `tx_data`, raises `tx_valid`, and clears bits 5 and 6. Both bits set again after a cycle with `tx_valid` and `tx_ready` high. A data write while a byte is pending is dropped.
- R8: Identification bits 2:0 follow this priority: any line error with enable bit2 gives 0b110; data-ready with enable bit0 gives 0b100; transmit-holding-empty with enable bit1 gives 0b010; any of modem status bits 3:0 with enable bit3 gives 0b000; otherwise 0b001.
- R9: `irq` is high exactly when identification bit0 is 0.
- R10: Writes to the identification register, line status or unmapped indices, and any cycle with `bus_sel` low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | One-cycle pulse per arriving byte |
| rx_data | input | 8 | Arriving byte |
| rx_perr | input | 1 | Parity error for the arriving byte |
| rx_ferr | input | 1 | Framing error for the arriving byte |
| rx_brk | input | 1 | Break seen with the arriving byte |
| rx_ready | output | 1 | Flow control: receive holding register empty |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Consumer accepts the transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the same-cycle collisions. In one, a byte arrives during a data read. A design that samples data-ready before the read would flag a false overrun and lose the byte. In another, an error arrives during a line-status read. A design that lets the clear win would drop the error. The bench also walks the interrupt ranking down one level at a time and checks that a modem change outside the low four bits raises nothing. A design with a swapped or missing level would report the wrong code there. Finally, it writes to read-only and unmapped indices and issues an unselected write, then reads everything back. Sloppy decoding would show up as a corrupted register.

// File: rtl/urb_pkg.sv
package urb_pkg;

    localparam int BYTE_W    = 8;
    localparam int IEN_W     = 4;
    localparam int MST_W     = 8;
    localparam int MST_EVT_W = 4;

    localparam int IDX_DATA = 0;
    localparam int IDX_IEN  = 1;
    localparam int IDX_IID  = 2;
    localparam int IDX_LST  = 5;
    localparam int IDX_MST  = 6;

    // Flags delivered alongside an arriving byte
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_line_t;

    // Sticky receive errors, line status bits 4:1
    typedef struct packed {
        logic bi;
        logic fe;
        logic pe;
        logic oe;
    } rx_err_t;

    // Interrupt enable, bits 3:0
    typedef struct packed {
        logic msi;
        logic rlsi;
        logic thri;
        logic rbri;
    } ien_t;

    // Line status byte
    typedef struct packed {
        logic    rsvd;
        logic    temt;
        logic    thre;
        rx_err_t err;
        logic    dr;
    } lst_t;

    typedef enum logic [2:0] {
        IID_NONE = 3'b001,
        IID_LINE = 3'b110,
        IID_RXD  = 3'b100,
        IID_TXE  = 3'b010,
        IID_MDM  = 3'b000
    } iid_e;

    function automatic logic err_any(input rx_err_t e);
        return e.oe | e.pe | e.fe | e.bi;
    endfunction

    function automatic rx_err_t err_merge(input rx_err_t base, input logic ovr,
                                          input logic take, input rx_line_t ln);
        rx_err_t r;
        r.oe = base.oe | ovr;
        r.pe = base.pe | (take & ln.perr);
        r.fe = base.fe | (take & ln.ferr);
        r.bi = base.bi | (take & ln.brk);
        return r;
    endfunction

endpackage

// File: rtl/urb_rx_hold.sv
module urb_rx_hold
    import urb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  rx_line_t          in_line,
    input  logic              data_rd,
    input  logic              lst_rd,
    output logic [BYTE_W-1:0] held_byte,
    output logic              ready_flag,
    output rx_err_t           err_q
);

    logic    take;
    logic    ovr;
    logic    dr_n;
    rx_err_t err_base;
    rx_err_t err_n;

    // A read in the same cycle frees the slot for the arriving byte
    assign take = in_valid & (~ready_flag | data_rd);
    assign ovr  = in_valid & ready_flag & ~data_rd;

    always_comb begin
        if (take)
            dr_n = 1'b1;
        else if (data_rd)
            dr_n = 1'b0;
        else
            dr_n = ready_flag;
    end

    always_comb begin
        err_base = lst_rd ? '0 : err_q;
        err_n    = err_merge(err_base, ovr, take, in_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_byte  <= '0;
            ready_flag <= 1'b0;
            err_q      <= '0;
        end else begin
            if (take)
                held_byte <= in_byte;
            ready_flag <= dr_n;
            err_q      <= err_n;
        end
    end

    AST_RX_TAKE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ready_flag) |=> (ready_flag && held_byte == $past(in_byte))); // R3

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !in_valid) |=> !ready_flag); // R4

    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ready_flag && !data_rd) |=> ($stable(held_byte) && err_q.oe)); // R5

    AST_ERR_SURVIVES: assert property (@(posedge clk) disable iff (rst)
        (lst_rd && in_valid && !ready_flag && in_line.ferr) |=> err_q.fe); // R6

endmodule

// File: rtl/urb_tx_hold.sv
module urb_tx_hold
    import urb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);

    logic              busy;
    logic              load;
    logic [BYTE_W-1:0] byte_q;

    // Loading is only possible from the empty state; a busy write is dropped
    assign load = wr_stb & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            byte_q <= '0;
        end else begin
            if (load) begin
                busy   <= 1'b1;
                byte_q <= wr_byte;
            end else if (busy && out_ready) begin
                busy <= 1'b0;
            end
        end
    end

    assign out_valid = busy;
    assign out_byte  = byte_q;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R7

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !out_valid) |=> (out_valid && out_byte == $past(wr_byte))); // R7

endmodule

// File: rtl/urb_irq_rank.sv
module urb_irq_rank
    import urb_pkg::*;
(
    input  lst_t                 lst,
    input  ien_t                 ien,
    input  logic [MST_EVT_W-1:0] mst_evt,
    output iid_e                 iid,
    output logic                 irq
);

    logic [3:0] cond;

    assign cond[3] = err_any(lst.err) & ien.rlsi;
    assign cond[2] = lst.dr & ien.rbri;
    assign cond[1] = lst.thre & ien.thri;
    assign cond[0] = (|mst_evt) & ien.msi;

    assign irq = |cond;

    always_comb begin
        if (cond[3])
            iid = IID_LINE;
        else if (cond[2])
            iid = IID_RXD;
        else if (cond[1])
            iid = IID_TXE;
        else if (cond[0])
            iid = IID_MDM;
        else
            iid = IID_NONE;
    end

    always_comb begin
        AST_IRQ_LEVEL: assert (irq == (iid != IID_NONE)); // R9
    end

endmodule

// File: rtl/urb_top.sv
module urb_top
    import urb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              rd_stb;
    logic              wr_stb;
    logic              data_rd;
    logic              data_wr;
    logic              lst_rd;
    ien_t              ien_q;
    logic [MST_W-1:0]  mst_q;
    logic [BYTE_W-1:0] rx_held;
    logic              dr;
    rx_err_t           rx_err;
    lst_t              lst;
    iid_e              iid;
    rx_line_t          rx_line;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:BYTE_W]};

    assign idx     = bus_addr[ADDR_W-1:2];
    assign rd_stb  = bus_sel & ~bus_we;
    assign wr_stb  = bus_sel & bus_we;
    assign data_rd = rd_stb & (idx == IDX_W'(IDX_DATA));
    assign data_wr = wr_stb & (idx == IDX_W'(IDX_DATA));
    assign lst_rd  = rd_stb & (idx == IDX_W'(IDX_LST));
    assign rx_line = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};

    urb_rx_hold u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid),
        .in_byte   (rx_data),
        .in_line   (rx_line),
        .data_rd   (data_rd),
        .lst_rd    (lst_rd),
        .held_byte (rx_held),
        .ready_flag(dr),
        .err_q     (rx_err)
    );

    urb_tx_hold u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (data_wr),
        .wr_byte  (bus_wdata[BYTE_W-1:0]),
        .out_ready(tx_ready),
        .out_valid(tx_valid),
        .out_byte (tx_data)
    );

    // No serializer here, so the shifter is empty whenever the holding slot is
    always_comb begin
        lst.rsvd = 1'b0;
        lst.temt = ~tx_valid;
        lst.thre = ~tx_valid;
        lst.err  = rx_err;
        lst.dr   = dr;
    end

    assign rx_ready = ~dr;

    urb_irq_rank u_rank (
        .lst    (lst),
        .ien    (ien_q),
        .mst_evt(mst_q[MST_EVT_W-1:0]),
        .iid    (iid),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            mst_q <= '0;
        end else if (wr_stb) begin
            if (idx == IDX_W'(IDX_IEN))
                ien_q <= bus_wdata[IEN_W-1:0];
            if (idx == IDX_W'(IDX_MST))
                mst_q <= bus_wdata[MST_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (idx)
                IDX_W'(IDX_DATA): bus_rdata[BYTE_W-1:0] = rx_held;
                IDX_W'(IDX_IEN):  bus_rdata[IEN_W-1:0]  = ien_q;
                IDX_W'(IDX_IID):  bus_rdata[2:0]        = iid;
                IDX_W'(IDX_LST):  bus_rdata[BYTE_W-1:0] = lst;
                IDX_W'(IDX_MST):  bus_rdata[MST_W-1:0]  = mst_q;
                default:          bus_rdata             = '0;
            endcase
        end
    end

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (err_any(rx_err) && ien_q.rlsi) |-> (iid == IID_LINE)); // R8

    AST_READY_FLOW: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && !data_rd) |=> $stable(rx_held)); // R5

    AST_NO_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> ($stable(ien_q) && $stable(mst_q))); // R10

endmodule

// File: tb/urb_top_test.sv
module urb_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_perr = 1'b0;
    logic        rx_ferr = 1'b0;
    logic        rx_brk = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    localparam int A_DATA = 0;
    localparam int A_IEN  = 4;
    localparam int A_IID  = 8;
    localparam int A_GAP3 = 12;
    localparam int A_GAP4 = 16;
    localparam int A_LST  = 20;
    localparam int A_MST  = 24;
    localparam int A_GAP7 = 28;

    urb_top uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic p, input logic f, input logic k);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_perr = p; rx_ferr = f; rx_brk = k;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    // Bus read and byte arrival in the same cycle
    task automatic rd_with_rx(input int a, input logic [7:0] b, input logic f,
                              output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(a);
        rx_valid = 1'b1; rx_data = b; rx_ferr = f;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        brd(A_LST, v); chk("R1 line status", v, 32'h60);
        brd(A_IEN, v); chk("R1 enable", v, 0);
        brd(A_MST, v); chk("R1 modem", v, 0);
        brd(A_IID, v); chk("R1 ident", v, 32'h1);
    endtask

    task automatic t_map();
        logic [31:0] v;
        bwr(A_IEN, 32'hFFFF_FFF5);
        brd(A_IEN, v); chk("R2 enable readback", v, 32'h5);
        bwr(A_MST, 32'h1234_56A0);
        brd(A_MST, v); chk("R2 modem readback", v, 32'hA0);
        bwr(A_IEN, 32'h0);
        brd(A_GAP3, v); chk("R2 unmapped 3", v, 0);
        brd(A_GAP4, v); chk("R2 unmapped 4", v, 0);
        brd(A_GAP7, v); chk("R2 unmapped 7", v, 0);
        brd(A_IEN + 2, v); chk("R2 low address bits ignored", v, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        bwr(A_IEN, 32'h3);
        bwr(A_LST, 32'h0);
        brd(A_LST, v); chk("R10 line status write ignored", v, 32'h60);
        bwr(A_IID, 32'hFF);
        brd(A_IID, v); chk("R10 ident write ignored", v, 32'h2);
        bwr(A_GAP3, 32'hFF);
        bwr(A_GAP7, 32'hFF);
        brd(A_IEN, v); chk("R10 unmapped write leaves enable", v, 32'h3);
        brd(A_MST, v); chk("R10 unmapped write leaves modem", v, 32'hA0);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 5'(A_IEN); bus_wdata = 32'hC;
        @(negedge clk);
        bus_we = 1'b0;
        brd(A_IEN, v); chk("R10 unselected write ignored", v, 32'h3);
        bwr(A_IEN, 32'h0);
        bwr(A_MST, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        rx_push(8'h3C, 1'b0, 1'b0, 1'b0);
        chk("R3 rx_ready low when held", 32'(rx_ready), 0);
        brd(A_LST, v); chk("R3 data ready", v, 32'h61);
        brd(A_DATA, v); chk("R4 held byte", v, 32'h3C);
        chk("R3 rx_ready back", 32'(rx_ready), 1);
        brd(A_LST, v); chk("R4 data ready cleared", v, 32'h60);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        rx_push(8'h11, 1'b0, 1'b0, 1'b0);
        rx_push(8'h22, 1'b1, 1'b1, 1'b1);
        brd(A_LST, v); chk("R5 overrun set, flags of dropped byte ignored", v, 32'h63);
        brd(A_LST, v); chk("R6 overrun cleared by read", v, 32'h61);
        brd(A_DATA, v); chk("R5 first byte kept", v, 32'h11);
        rx_push(8'h33, 1'b0, 1'b0, 1'b0);
        rd_with_rx(A_DATA, 8'h44, 1'b0, v);
        chk("R4 read during arrival returns old", v, 32'h33);
        brd(A_LST, v); chk("R5 no overrun on same-cycle read", v, 32'h61);
        brd(A_DATA, v); chk("R5 new byte accepted", v, 32'h44);
    endtask

    task automatic t_err();
        logic [31:0] v;
        rx_push(8'h5A, 1'b1, 1'b0, 1'b1);
        brd(A_LST, v); chk("R6 parity and break", v, 32'h75);
        brd(A_LST, v); chk("R6 errors cleared", v, 32'h61);
        brd(A_DATA, v); chk("R6 byte", v, 32'h5A);
        rd_with_rx(A_LST, 8'h0F, 1'b1, v);
        chk("R6 read before arrival", v, 32'h60);
        brd(A_LST, v); chk("R6 framing survives read", v, 32'h69);
        brd(A_LST, v); chk("R6 framing then cleared", v, 32'h61);
        brd(A_DATA, v);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        @(negedge clk); tx_ready = 1'b0;
        bwr(A_DATA, 32'h1234_ABCD);
        chk("R7 tx_valid", 32'(tx_valid), 1);
        chk("R7 tx_data low byte", 32'(tx_data), 32'hCD);
        brd(A_LST, v); chk("R7 holding not empty", v, 32'h00);
        bwr(A_DATA, 32'h77);
        chk("R7 busy write dropped", 32'(tx_data), 32'hCD);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk);
        chk("R7 tx drained", 32'(tx_valid), 0);
        brd(A_LST, v); chk("R7 holding empty again", v, 32'h60);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        bwr(A_IEN, 32'hF);
        brd(A_IID, v); chk("R8 transmit empty", v, 32'h2);
        chk("R9 irq on", 32'(irq), 1);
        bwr(A_MST, 32'h1);
        brd(A_IID, v); chk("R8 transmit above modem", v, 32'h2);
        rx_push(8'h55, 1'b0, 1'b0, 1'b0);
        brd(A_IID, v); chk("R8 receive above transmit", v, 32'h4);
        rx_push(8'h66, 1'b0, 1'b0, 1'b0);
        brd(A_IID, v); chk("R8 line error first", v, 32'h6);
        brd(A_LST, v); chk("R5 overrun in status", v, 32'h63);
        brd(A_IID, v); chk("R8 back to receive", v, 32'h4);
        brd(A_DATA, v); chk("R4 byte", v, 32'h55);
        brd(A_IID, v); chk("R8 back to transmit", v, 32'h2);
        @(negedge clk); tx_ready = 1'b0;
        bwr(A_DATA, 32'h99);
        brd(A_IID, v); chk("R8 modem last", v, 32'h0);
        chk("R9 irq for modem", 32'(irq), 1);
        bwr(A_MST, 32'h10);
        brd(A_IID, v); chk("R8 upper modem bits ignored", v, 32'h1);
        chk("R9 irq off", 32'(irq), 0);
        rx_push(8'h01, 1'b0, 1'b0, 1'b0);
        bwr(A_IEN, 32'h0);
        brd(A_IID, v); chk("R8 disabled source", v, 32'h1);
        chk("R9 irq off when disabled", 32'(irq), 0);
        brd(A_DATA, v);
        @(negedge clk); tx_ready = 1'b1;
        bwr(A_MST, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_ignored();
        t_rx();
        t_overrun();
        t_err();
        t_tx();
        t_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule